// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a bank of eight independent lock flags shared between a left and a right port. Either side asks for a flag by writing 0 to it and gives the flag back by writing 1. Only bit 0 of the written data matters.

If the other side already holds the flag, the request is not lost. It is kept as a pending request, and the flag passes to the waiting side as soon as the holder releases it. A waiting side can withdraw its request by writing 1.

Each side reads a status view relative to itself. A read shows 0 on all 18 data bits when this side holds the selected flag, and 1 otherwise. Software on each side polls this view to learn whether it owns a flag.

Top module: `sem_bank`

## Requirements
- R1: A port reaches the flag bank only when its enable `en0` is 1, its `en1_n` is 0 and its `sem_n` is 0. Any other combination leaves every flag unchanged and leaves that port's `dout` holding its previous value.
- R2: The 3-bit `idx` selects one of eight flags. A write changes only the flag it selects.
- R3: Every access in cycle N updates `dout` after the clock edge that ends cycle N. All 18 bits of `dout` then equal the selected flag's status as it stood before that edge: 0 if this side held the flag, 1 if it did not. The value then holds until the next access.
- R4: After reset every flag is free, with no pending requests, and both `dout` buses read all ones.
- R5: Writing 0 (`wr_n`=0, `din`=0) to a free flag makes the writing side the owner.
- R6: A 0 written by the side that does not own the flag leaves ownership unchanged. The write is recorded as a pending request.
- R7: When the owner writes 1 while the other side has a pending request, ownership passes to the other side. A request written by the other side in that same cycle counts as pending.
- R8: When the owner writes 1 and no request is pending, the flag becomes free.
- R9: A 1 written by the non-owner withdraws its pending request, so a later release by the owner frees the flag.
- R10: If both sides write 0 to the same free flag in one cycle, the left side becomes owner and the right request becomes pending.
- R11: No flag is ever owned by both sides at once.
- R12: A 0 written by the owner, or a 1 written to a free flag, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| l_en0 | input | 1 | Left enable, active high |
| l_en1_n | input | 1 | Left enable, active low |
| l_sem_n | input | 1 | Left flag-space select, active low |
| l_wr_n | input | 1 | Left write strobe, active low (1 = read) |
| l_idx | input | 3 | Left flag index |
| l_din | input | 1 | Left write data bit 0 |
| l_dout | output | 18 | Left status view of the selected flag |
| r_en0 | input | 1 | Right enable, active high |
| r_en1_n | input | 1 | Right enable, active low |
| r_sem_n | input | 1 | Right flag-space select, active low |
| r_wr_n | input | 1 | Right write strobe, active low (1 = read) |
| r_idx | input | 3 | Right flag index |
| r_din | input | 1 | Right write data bit 0 |
| r_dout | output | 18 | Right status view of the selected flag |

## Verification
Ownership changes take effect at the edge that ends the write cycle, and `dout` carries the pre-edge status of the selected flag one edge after the access. A read issued in the cycle after a write therefore shows that write's result.

The bench drives each access at a falling edge and updates its own model of owners and pending requests for the rising edge that follows. It samples both `dout` buses at the next falling edge, against the status its model held before that rising edge. Ports with no access are checked to hold their last value.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/sem_rst_sync.sv
module sem_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int NUM_SEM = 8,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic               en0,
  input  logic               en1_n,
  input  logic               sem_n,
  input  logic               wr_n,
  input  logic [IDX_W-1:0]   idx,
  input  logic               din,
  output logic               hit,
  output logic [NUM_SEM-1:0] claim,
  output logic [NUM_SEM-1:0] release_req
);
  logic wr_hit;

  assign hit    = en0 & ~en1_n & ~sem_n;
  assign wr_hit = hit & ~wr_n;

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_sel
    logic sel;
    assign sel            = (idx == IDX_W'(g));
    assign claim[g]       = wr_hit & sel & ~din;
    assign release_req[g] = wr_hit & sel &  din;
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic l_claim,
  input  logic l_rel,
  input  logic r_claim,
  input  logic r_rel,
  output logic own_l,
  output logic own_r,
  output logic pend_l,
  output logic pend_r
);
  owner_e owner_q, owner_d;
  logic   pl_q, pl_d, pr_q, pr_d;
  logic   wait_l, wait_r, upd;

  assign wait_l = (pl_q | l_claim) & ~l_rel;
  assign wait_r = (pr_q | r_claim) & ~r_rel;
  assign upd    = l_claim | l_rel | r_claim | r_rel;

  always_comb begin
    owner_d = owner_q;
    pl_d    = 1'b0;
    pr_d    = 1'b0;
    case (owner_q)
      OWN_NONE: begin
        if (l_claim) begin
          owner_d = OWN_LEFT;
          pr_d    = r_claim;
        end else if (r_claim) begin
          owner_d = OWN_RIGHT;
        end
      end
      OWN_LEFT: begin
        if (l_rel) owner_d = wait_r ? OWN_RIGHT : OWN_NONE;
        else       pr_d    = wait_r;
      end
      OWN_RIGHT: begin
        if (r_rel) owner_d = wait_l ? OWN_LEFT : OWN_NONE;
        else       pl_d    = wait_l;
      end
      default: owner_d = OWN_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= OWN_NONE;
      pl_q    <= 1'b0;
      pr_q    <= 1'b0;
    end else if (upd) begin
      owner_q <= owner_d;
      pl_q    <= pl_d;
      pr_q    <= pr_d;
    end
  end

  assign own_l  = (owner_q == OWN_LEFT);
  assign own_r  = (owner_q == OWN_RIGHT);
  assign pend_l = pl_q;
  assign pend_r = pr_q;
endmodule

// File: rtl/sem_readback.sv
module sem_readback #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 18,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit,
  input  logic [IDX_W-1:0]   idx,
  input  logic [NUM_SEM-1:0] own,
  output logic [DATA_W-1:0]  dout
);
  logic [DATA_W-1:0] dout_d;

  assign dout_d = {DATA_W{~own[idx]}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   dout <= '1;
    else if (hit) dout <= dout_d;
  end
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 18,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en0,
  input  logic              l_en1_n,
  input  logic              l_sem_n,
  input  logic              l_wr_n,
  input  logic [IDX_W-1:0]  l_idx,
  input  logic              l_din,
  output logic [DATA_W-1:0] l_dout,
  input  logic              r_en0,
  input  logic              r_en1_n,
  input  logic              r_sem_n,
  input  logic              r_wr_n,
  input  logic [IDX_W-1:0]  r_idx,
  input  logic              r_din,
  output logic [DATA_W-1:0] r_dout
);
  logic               rst_n_sync;
  logic               l_hit, r_hit;
  logic [NUM_SEM-1:0] l_claim, l_rel, r_claim, r_rel;
  logic [NUM_SEM-1:0] own_l, own_r, pend_l, pend_r;

  sem_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync));

  sem_port_dec #(.NUM_SEM(NUM_SEM)) u_dec_l (
    .en0(l_en0), .en1_n(l_en1_n), .sem_n(l_sem_n), .wr_n(l_wr_n),
    .idx(l_idx), .din(l_din), .hit(l_hit), .claim(l_claim), .release_req(l_rel)
  );

  sem_port_dec #(.NUM_SEM(NUM_SEM)) u_dec_r (
    .en0(r_en0), .en1_n(r_en1_n), .sem_n(r_sem_n), .wr_n(r_wr_n),
    .idx(r_idx), .din(r_din), .hit(r_hit), .claim(r_claim), .release_req(r_rel)
  );

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
    sem_cell u_cell (
      .clk(clk), .rst_n(rst_n_sync),
      .l_claim(l_claim[g]), .l_rel(l_rel[g]),
      .r_claim(r_claim[g]), .r_rel(r_rel[g]),
      .own_l(own_l[g]), .own_r(own_r[g]),
      .pend_l(pend_l[g]), .pend_r(pend_r[g])
    );
  end

  sem_readback #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rb_l (
    .clk(clk), .rst_n(rst_n_sync), .hit(l_hit), .idx(l_idx), .own(own_l), .dout(l_dout)
  );

  sem_readback #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rb_r (
    .clk(clk), .rst_n(rst_n_sync), .hit(r_hit), .idx(r_idx), .own(own_r), .dout(r_dout)
  );
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 18,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               l_en0, l_en1_n, l_sem_n, l_wr_n, l_din,
  input logic [IDX_W-1:0]   l_idx,
  input logic [DATA_W-1:0]  l_dout,
  input logic               r_en0, r_en1_n, r_sem_n, r_wr_n, r_din,
  input logic [IDX_W-1:0]   r_idx,
  input logic [DATA_W-1:0]  r_dout,
  input logic [NUM_SEM-1:0] own_l, own_r, pend_l, pend_r
);
  logic lh, rh, lw0, lw1, rw0, rw1, same;
  assign lh   = l_en0 & ~l_en1_n & ~l_sem_n;
  assign rh   = r_en0 & ~r_en1_n & ~r_sem_n;
  assign lw0  = lh & ~l_wr_n & ~l_din;
  assign lw1  = lh & ~l_wr_n &  l_din;
  assign rw0  = rh & ~r_wr_n & ~r_din;
  assign rw1  = rh & ~r_wr_n &  r_din;
  assign same = (l_idx == r_idx);

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l & own_r) == '0);

  a_r5_claim_free: assert property (@(posedge clk) disable iff (!rst_n)
    (lw0 && !own_r[l_idx]) |=> own_l[$past(l_idx)]);

  a_r6_no_steal: assert property (@(posedge clk) disable iff (!rst_n)
    (rw0 && own_l[r_idx] && !(lw1 && same)) |=> (own_l[$past(r_idx)] && pend_r[$past(r_idx)]));

  a_r7_handover: assert property (@(posedge clk) disable iff (!rst_n)
    (lw1 && own_l[l_idx] && pend_r[l_idx] && !(rw1 && same)) |=> own_r[$past(l_idx)]);

  a_r8_release_free: assert property (@(posedge clk) disable iff (!rst_n)
    (lw1 && own_l[l_idx] && !pend_r[l_idx] && !(rw0 && same))
      |=> (!own_l[$past(l_idx)] && !own_r[$past(l_idx)]));

  a_r10_left_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (lw0 && rw0 && same && !own_l[l_idx] && !own_r[l_idx])
      |=> (own_l[$past(l_idx)] && pend_r[$past(l_idx)]));

  a_r3_readback: assert property (@(posedge clk) disable iff (!rst_n)
    lh |=> (l_dout == {DATA_W{!$past(own_l[l_idx])}}));

  a_r1_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rh |=> $stable(r_dout));
endmodule

bind sem_bank sem_bank_chk #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n_sync),
  .l_en0(l_en0), .l_en1_n(l_en1_n), .l_sem_n(l_sem_n), .l_wr_n(l_wr_n), .l_din(l_din),
  .l_idx(l_idx), .l_dout(l_dout),
  .r_en0(r_en0), .r_en1_n(r_en1_n), .r_sem_n(r_sem_n), .r_wr_n(r_wr_n), .r_din(r_din),
  .r_idx(r_idx), .r_dout(r_dout),
  .own_l(own_l), .own_r(own_r), .pend_l(pend_l), .pend_r(pend_r)
);

// File: tb/sem_bank_test.sv
module sem_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int DW = 18;
  // op codes: 0 idle, 1 read, 2 write din, 3 write with a broken enable
  localparam int OP_IDLE = 0, OP_RD = 1, OP_WR = 2, OP_BAD = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic l_en0, l_en1_n, l_sem_n, l_wr_n, l_din;
  logic r_en0, r_en1_n, r_sem_n, r_wr_n, r_din;
  logic [2:0] l_idx, r_idx;
  logic [DW-1:0] l_dout, r_dout;

  int n_chk = 0, n_fail = 0;
  int m_own [N];          // 0 free, 1 left, 2 right
  bit m_pl [N], m_pr [N];
  logic [DW-1:0] e_ld, e_rd;
  int unsigned rng = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  sem_bank uut (
    .clk(clk), .rst_n(rst_n),
    .l_en0(l_en0), .l_en1_n(l_en1_n), .l_sem_n(l_sem_n), .l_wr_n(l_wr_n),
    .l_idx(l_idx), .l_din(l_din), .l_dout(l_dout),
    .r_en0(r_en0), .r_en1_n(r_en1_n), .r_sem_n(r_sem_n), .r_wr_n(r_wr_n),
    .r_idx(r_idx), .r_din(r_din), .r_dout(r_dout)
  );

  task automatic chk(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic drive_l(int op, int idx, bit b);
    l_en0 = (op != OP_IDLE); l_en1_n = 1'b0; l_sem_n = 1'b0;
    l_wr_n = !(op == OP_WR || op == OP_BAD); l_idx = 3'(idx); l_din = b;
    if (op == OP_BAD) begin
      case (idx % 3)
        0: l_en0 = 1'b0;
        1: l_en1_n = 1'b1;
        default: l_sem_n = 1'b1;
      endcase
    end
  endtask

  task automatic drive_r(int op, int idx, bit b);
    r_en0 = (op != OP_IDLE); r_en1_n = 1'b0; r_sem_n = 1'b0;
    r_wr_n = !(op == OP_WR || op == OP_BAD); r_idx = 3'(idx); r_din = b;
    if (op == OP_BAD) begin
      case (idx % 3)
        0: r_en0 = 1'b0;
        1: r_en1_n = 1'b1;
        default: r_sem_n = 1'b1;
      endcase
    end
  endtask

  // model of the rules in R5..R10, R12
  task automatic model(int lop, int li, bit lb, int rop, int ri, bit rb);
    if (lop == OP_RD || lop == OP_WR) e_ld = {DW{m_own[li] != 1}};
    if (rop == OP_RD || rop == OP_WR) e_rd = {DW{m_own[ri] != 2}};
    for (int i = 0; i < N; i++) begin
      bit lc, lr, rc, rr, wl, wr;
      lc = (lop == OP_WR) && (li == i) && !lb;
      lr = (lop == OP_WR) && (li == i) &&  lb;
      rc = (rop == OP_WR) && (ri == i) && !rb;
      rr = (rop == OP_WR) && (ri == i) &&  rb;
      wl = (m_pl[i] || lc) && !lr;
      wr = (m_pr[i] || rc) && !rr;
      if (m_own[i] == 0) begin
        if (lc)      begin m_own[i] = 1; m_pr[i] = rc; end
        else if (rc) m_own[i] = 2;
      end else if (m_own[i] == 1) begin
        if (lr) begin m_own[i] = wr ? 2 : 0; m_pr[i] = 0; end
        else    m_pr[i] = wr;
        m_pl[i] = 0;
      end else begin
        if (rr) begin m_own[i] = wl ? 1 : 0; m_pl[i] = 0; end
        else    m_pl[i] = wl;
        m_pr[i] = 0;
      end
    end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(int lop, int li, bit lb, int rop, int ri, bit rb, string tag);
    drive_l(lop, li, lb);
    drive_r(rop, ri, rb);
    model(lop, li, lb, rop, ri, rb);
    @(negedge clk);
    chk({tag, " left"},  l_dout, e_ld);
    chk({tag, " right"}, r_dout, e_rd);
  endtask

  task automatic probe(int idx, bit el, bit er, string tag);
    step(OP_RD, idx, 0, OP_RD, idx, 0, tag);
    chk({tag, " left view"},  l_dout, {DW{el}});
    chk({tag, " right view"}, r_dout, {DW{er}});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_own[i] = 0; m_pl[i] = 0; m_pr[i] = 0; end
    e_ld = '1; e_rd = '1;
    drive_l(OP_IDLE, 0, 0); drive_r(OP_IDLE, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 reset left dout", l_dout, '1);
    chk("R4 reset right dout", r_dout, '1);
    for (int i = 0; i < N; i++) probe(i, 1, 1, "R4 free after reset");

    step(OP_WR, 3, 0, OP_IDLE, 0, 0, "R5 left claim");
    probe(3, 0, 1, "R5 left owns");
    step(OP_IDLE, 0, 0, OP_WR, 3, 0, "R6 right request");
    probe(3, 0, 1, "R6 owner unchanged");
    step(OP_WR, 3, 0, OP_IDLE, 0, 0, "R12 owner rewrites 0");
    probe(3, 0, 1, "R12 still owner");
    step(OP_WR, 3, 1, OP_IDLE, 0, 0, "R7 release to waiter");
    probe(3, 1, 0, "R7 right now owns");
    step(OP_WR, 3, 0, OP_IDLE, 0, 0, "R9 left request");
    step(OP_WR, 3, 1, OP_IDLE, 0, 0, "R9 left withdraw");
    step(OP_IDLE, 0, 0, OP_WR, 3, 1, "R8 right release");
    probe(3, 1, 1, "R9 R8 flag free");
    step(OP_IDLE, 0, 0, OP_WR, 3, 1, "R12 release of free");
    probe(3, 1, 1, "R12 free stays free");

    step(OP_WR, 5, 0, OP_WR, 5, 0, "R10 tie");
    probe(5, 0, 1, "R10 left wins");
    step(OP_WR, 5, 1, OP_IDLE, 0, 0, "R10 left release");
    probe(5, 1, 0, "R10 pending right served");
    probe(4, 1, 1, "R2 neighbour below untouched");
    probe(6, 1, 1, "R2 neighbour above untouched");

    step(OP_WR, 1, 0, OP_IDLE, 0, 0, "R7 setup");
    step(OP_WR, 1, 1, OP_WR, 1, 0, "R7 same-cycle request");
    probe(1, 1, 0, "R7 same-cycle handover");

    for (int k = 0; k < 3; k++) begin
      step(OP_BAD, k, 0, OP_IDLE, 0, 0, "R1 gated write");
      chk("R1 dout held", l_dout, e_ld);
      probe(k, (k == 1) ? 1'b1 : 1'b1, (k == 1) ? 1'b0 : 1'b1, "R1 flag unchanged");
    end

    for (int s = 0; s < 4000; s++) begin
      int lop, li, rop, ri;
      bit lb, rb;
      rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
      lop = int'(rng[1:0]); li = int'(rng[4:2]); lb = rng[5];
      rop = int'(rng[7:6]); rb = rng[12];
      ri  = rng[8] ? li : int'(rng[11:9]);
      step(lop, li, lb, rop, ri, rb, "R3 R11 sweep");
    end
    for (int i = 0; i < N; i++) begin
      step(OP_RD, i, 0, OP_RD, i, 0, "R11 final sweep");
      chk("R11 not both owners", {17'd0, l_dout[0] | r_dout[0]}, 18'd1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule